// File: doc/BRIEF.md
# Serial-Bus PHY Base Register Bank

This block is the small configuration and status register bank of a multi-port serial-bus physical-layer controller. A link-side controller reaches it through a plain read/write port with a 4-bit address and 8-bit data. The bank keeps the node's identity, its root status, the arbitration gap count, the link-control and contender flags and the node power class. It also publishes the values that the self-ID packet generator copies into each self-ID packet.

Two kinds of reset act on the bank. The hardware reset is the asynchronous active-low `rst_n`. A bus reset is a one-cycle event pulse from the arbitration logic. Each field follows its own rule for each kind of reset. The arbitration logic also feeds in self-ID completion, root election and configuration-packet gap updates. In return, the bank drives a long bus-reset request that is held back while a receive or transmit is in progress.

The read path is combinational. `rd_data` follows `addr` and the current register contents in the same cycle. A write takes effect at the clock edge where `wr_en` is sampled high.

Top module: `phy_base_regs`

## Requirements
- R1: Address 2 always reads 0xE3 (extended-set code 111b in bits 7:5, bit 4 zero, port count 3 in bits 3:0). Address 3 always reads 0x40 (speed code 010b in bits 7:5, bit 4 zero, delay 0 in bits 3:0).
- R2: A `selfid_done` pulse loads `selfid_id` into the node ID, which reads at address 0 bits 7:2. At the same edge it raises `phy_id_valid`. In the following cycle it gives a single-cycle `status_report` pulse. A bus reset drops `phy_id_valid` to 0.
- R3: The root flag (address 0 bit 1) is set by `root_won` and cleared by every bus reset. A bus reset takes priority over `root_won` in the same cycle.
- R4: The root-holdoff bit (address 1 bit 7) is writable, reads 0 after hardware reset and keeps its value across a bus reset. It is also driven on `root_holdoff`.
- R5: The initiate-bus-reset bit (address 1 bit 6) is writable. `bus_reset_req` is high only while that bit is 1 and `link_busy` is 0. A bus reset clears the bit.
- R6: The gap count (address 1 bits 5:0, also on `gap_count`) is loaded by a write to address 1 or by `cfg_gap_valid` with `cfg_gap_value`. A register write wins when both occur in the same cycle.
- R7: A bus reset that arrives after an earlier bus reset, with no gap-count update between them, forces the gap count to 0x3F. A single bus reset after an update leaves the gap count unchanged.
- R8: The link-control bit (address 4 bit 7) reads 1 after hardware reset, is writable and is unaffected by bus reset. `selfid_link_active` equals that bit ANDed with `link_power_on`.
- R9: At hardware reset, the contender bit (address 4 bit 6) loads from `strap_contender` and the power class (address 4 bits 2:0) loads from `strap_pwr_class`. Both are writable and unaffected by bus reset. They are copied to `selfid_contender` and `selfid_pwr_class`. Address 4 bits 5:3 (jitter) read 0.
- R10: Address 0 bit 0 reflects the live level of `cable_pwr_ok`.
- R11: Addresses 5 to 15 read 0. Writes to addresses 0, 2, 3 and 5 to 15 change nothing, and a write to address 4 cannot change bits 5:3.
- R12: After hardware reset, address 0 reads 0 apart from the live bit 0, address 1 reads 0x3F and `phy_id_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| strap_contender | input | 1 | Contender value loaded at hardware reset |
| strap_pwr_class | input | 3 | Power class loaded at hardware reset |
| cable_pwr_ok | input | 1 | Cable supply above threshold |
| link_power_on | input | 1 | Link power-status input |
| link_busy | input | 1 | Receive or transmit in progress |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| bus_reset_evt | input | 1 | One-cycle pulse: a bus reset occurred |
| selfid_done | input | 1 | One-cycle pulse: self-ID finished |
| selfid_id | input | 6 | Node ID assigned by self-ID |
| root_won | input | 1 | Pulse: tree-ID chose this node as root |
| cfg_gap_valid | input | 1 | Configuration packet carries a gap count |
| cfg_gap_value | input | 6 | Gap count from the configuration packet |
| bus_reset_req | output | 1 | Request to start a long bus reset |
| phy_id_valid | output | 1 | Node ID is valid |
| status_report | output | 1 | Unsolicited register-0 status pulse |
| gap_count | output | 6 | Current gap count |
| root_holdoff | output | 1 | Try to become root after the next bus reset |
| selfid_link_active | output | 1 | Link-active bit for self-ID |
| selfid_contender | output | 1 | Contender bit for self-ID |
| selfid_pwr_class | output | 3 | Power field for self-ID |

## Verification
The riskiest state is the one-bit memory of an earlier bus reset. If that bit is lost or stuck, the second of two consecutive bus resets leaves a stale gap count in place of 0x3F, or a single bus reset wipes a freshly written value. Either error is visible at address 1 in the cycle right after the bus reset. A field that reacts to the wrong kind of reset shows the wrong value at its address, or on its self-ID output, one cycle after the offending reset. A wrongly decoded address shows at once as nonzero data in a reserved slot, or as a constant that no longer matches.

// File: rtl/phy_regs_pkg.sv
package phy_regs_pkg;
    parameter int ADDR_W = 4;
    parameter int DATA_W = 8;
    parameter int ID_W   = 6;
    parameter int GAP_W  = 6;
    parameter int PWR_W  = 3;

    parameter logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    parameter logic [2:0] EXT_CODE    = 3'b111;
    parameter logic [3:0] PORT_COUNT  = 4'd3;
    parameter logic [2:0] SPEED_CODE  = 3'b010;
    parameter logic [3:0] DELAY_CODE  = 4'd0;
    parameter logic [2:0] JITTER_CODE = 3'd0;

    parameter logic [ADDR_W-1:0] ADR_IDENT = 4'd0;
    parameter logic [ADDR_W-1:0] ADR_CTRL  = 4'd1;
    parameter logic [ADDR_W-1:0] ADR_CAPS  = 4'd2;
    parameter logic [ADDR_W-1:0] ADR_SPEED = 4'd3;
    parameter logic [ADDR_W-1:0] ADR_NODE  = 4'd4;

    typedef struct packed {
        logic [ID_W-1:0]  phy_id;
        logic             id_valid;
        logic             root;
        logic             holdoff;
        logic             ibr;
        logic             lctrl;
        logic             contender;
        logic [PWR_W-1:0] pwr;
        logic             status_pulse;
    } node_state_t;

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic             pending;
    } gap_state_t;
endpackage

// File: rtl/gap_tracker.sv
module gap_tracker
    import phy_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             wr_upd,
    input  logic [GAP_W-1:0] wr_val,
    input  logic             cfg_upd,
    input  logic [GAP_W-1:0] cfg_val,
    output logic [GAP_W-1:0] gap_out
);
    gap_state_t gs_d, gs_q;
    logic       any_upd;

    assign any_upd = wr_upd | cfg_upd;

    always_comb begin
        gs_d = gs_q;
        if (bus_reset) begin
            gs_d.pending = 1'b1;
            if (gs_q.pending) begin
                gs_d.gap = GAP_MAX;
            end
        end
        if (any_upd) begin
            gs_d.gap     = wr_upd ? wr_val : cfg_val;
            gs_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gs_q.gap     <= GAP_MAX;
            gs_q.pending <= 1'b0;
        end else begin
            gs_q <= gs_d;
        end
    end

    assign gap_out = gs_q.gap;

    // R7: second bus reset without an update restores the maximum
    assert_two_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !any_upd && gs_q.pending) |=> (gap_out == GAP_MAX));

    // R7: a first bus reset leaves the gap count untouched
    assert_first_reset_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !any_upd && !gs_q.pending) |=> $stable(gap_out));

    // R6: register write wins over a configuration packet
    assert_write_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_upd && cfg_upd) |=> (gap_out == $past(wr_val)));
endmodule

// File: rtl/reg_readback.sv
module reg_readback
    import phy_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  node_state_t       st,
    input  logic [GAP_W-1:0]  gap,
    input  logic              cable_pwr_ok,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        case (addr)
            ADR_IDENT: rd_data = {st.phy_id, st.root, cable_pwr_ok};
            ADR_CTRL:  rd_data = {st.holdoff, st.ibr, gap};
            ADR_CAPS:  rd_data = {EXT_CODE, 1'b0, PORT_COUNT};
            ADR_SPEED: rd_data = {SPEED_CODE, 1'b0, DELAY_CODE};
            ADR_NODE:  rd_data = {st.lctrl, st.contender, JITTER_CODE, st.pwr};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/phy_base_regs.sv
module phy_base_regs
    import phy_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_contender,
    input  logic [PWR_W-1:0]  strap_pwr_class,
    input  logic              cable_pwr_ok,
    input  logic              link_power_on,
    input  logic              link_busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              bus_reset_evt,
    input  logic              selfid_done,
    input  logic [ID_W-1:0]   selfid_id,
    input  logic              root_won,
    input  logic              cfg_gap_valid,
    input  logic [GAP_W-1:0]  cfg_gap_value,
    output logic              bus_reset_req,
    output logic              phy_id_valid,
    output logic              status_report,
    output logic [GAP_W-1:0]  gap_count,
    output logic              root_holdoff,
    output logic              selfid_link_active,
    output logic              selfid_contender,
    output logic [PWR_W-1:0]  selfid_pwr_class
);
    node_state_t st_d, st_q;
    logic        wr_ctrl, wr_node;

    assign wr_ctrl = wr_en && (addr == ADR_CTRL);
    assign wr_node = wr_en && (addr == ADR_NODE);

    always_comb begin
        st_d              = st_q;
        st_d.status_pulse = 1'b0;
        if (wr_ctrl) begin
            st_d.holdoff = wr_data[7];
            st_d.ibr     = wr_data[6];
        end
        if (wr_node) begin
            st_d.lctrl     = wr_data[7];
            st_d.contender = wr_data[6];
            st_d.pwr       = wr_data[PWR_W-1:0];
        end
        if (root_won) begin
            st_d.root = 1'b1;
        end
        if (bus_reset_evt) begin
            st_d.root     = 1'b0;
            st_d.ibr      = 1'b0;
            st_d.id_valid = 1'b0;
        end
        if (selfid_done) begin
            st_d.phy_id       = selfid_id;
            st_d.id_valid     = 1'b1;
            st_d.status_pulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phy_id       <= '0;
            st_q.id_valid     <= 1'b0;
            st_q.root         <= 1'b0;
            st_q.holdoff      <= 1'b0;
            st_q.ibr          <= 1'b0;
            st_q.lctrl        <= 1'b1;
            st_q.contender    <= strap_contender;
            st_q.pwr          <= strap_pwr_class;
            st_q.status_pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    gap_tracker u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset_evt),
        .wr_upd    (wr_ctrl),
        .wr_val    (wr_data[GAP_W-1:0]),
        .cfg_upd   (cfg_gap_valid),
        .cfg_val   (cfg_gap_value),
        .gap_out   (gap_count)
    );

    reg_readback u_rd (
        .addr         (addr),
        .st           (st_q),
        .gap          (gap_count),
        .cable_pwr_ok (cable_pwr_ok),
        .rd_data      (rd_data)
    );

    assign bus_reset_req      = st_q.ibr & ~link_busy;
    assign phy_id_valid       = st_q.id_valid;
    assign status_report      = st_q.status_pulse;
    assign root_holdoff       = st_q.holdoff;
    assign selfid_link_active = st_q.lctrl & link_power_on;
    assign selfid_contender   = st_q.contender;
    assign selfid_pwr_class   = st_q.pwr;

    // R2: self-ID completion validates the ID and reports once
    assert_selfid_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        selfid_done |=> (phy_id_valid && status_report));
    assert_status_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_report && !$past(selfid_done, 2)) |=> !status_report);

    // R3: bus reset clears root
    assert_root_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_evt |=> !rd_data[1] || (addr != ADR_IDENT) || !st_q.root);

    // R5: bus reset withdraws the request
    assert_ibr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_evt |=> !bus_reset_req);

    // R8 / R9 / R4: node settings survive a bus reset
    assert_node_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_evt && !wr_node) |=> ($stable(selfid_contender) && $stable(selfid_pwr_class)));
    assert_holdoff_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_evt && !wr_ctrl) |=> $stable(root_holdoff));
endmodule

// File: tb/tb_phy_base_regs.sv
`timescale 1ns/1ps
module tb_phy_base_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_contender = 1'b0;
    logic [2:0] strap_pwr_class = 3'd0;
    logic       cable_pwr_ok = 1'b1;
    logic       link_power_on = 1'b1;
    logic       link_busy = 1'b0;
    logic [3:0] addr = 4'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       bus_reset_evt = 1'b0;
    logic       selfid_done = 1'b0;
    logic [5:0] selfid_id = 6'd0;
    logic       root_won = 1'b0;
    logic       cfg_gap_valid = 1'b0;
    logic [5:0] cfg_gap_value = 6'd0;
    logic       bus_reset_req, phy_id_valid, status_report, root_holdoff;
    logic [5:0] gap_count;
    logic       selfid_link_active, selfid_contender;
    logic [2:0] selfid_pwr_class;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    phy_base_regs dut (.*);

    task automatic chk(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic bus_reset();
        bus_reset_evt = 1'b1;
        tick();
        bus_reset_evt = 1'b0;
    endtask

    task automatic hw_reset(input logic c, input logic [2:0] pc);
        strap_contender = c; strap_pwr_class = pc;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #800000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        // R12 / R9 / R8: sweep all strap combinations
        for (int s = 0; s < 16; s++) begin
            hw_reset(s[3], s[2:0]);
            rd(4'd4, v);
            chk("R9 node reg after reset", v, 8'h80 | (s[3] << 6) | s[2:0]);
            chk("R9 selfid contender", selfid_contender, s[3]);
            chk("R9 selfid pwr", selfid_pwr_class, s[2:0]);
            chk("R8 link active", selfid_link_active, 1);
            rd(4'd0, v);
            chk("R12 ident after reset", v, 8'h01);
            rd(4'd1, v);
            chk("R12 ctrl after reset", v, 8'h3F);
            chk("R12 id valid after reset", phy_id_valid, 0);
        end
        // R1: constants
        rd(4'd2, v); chk("R1 caps", v, 8'hE3);
        rd(4'd3, v); chk("R1 speed", v, 8'h40);
        // R11: reserved space and read-only writes
        for (int a = 5; a < 16; a++) begin
            wr(a[3:0], 8'hFF);
            rd(a[3:0], v); chk("R11 reserved zero", v, 0);
        end
        wr(4'd0, 8'hFF); wr(4'd2, 8'h00); wr(4'd3, 8'hFF);
        rd(4'd0, v); chk("R11 ident untouched", v, 8'h01);
        rd(4'd2, v); chk("R11 caps untouched", v, 8'hE3);
        rd(4'd3, v); chk("R11 speed untouched", v, 8'h40);
        rd(4'd1, v); chk("R11 ctrl untouched", v, 8'h3F);
        wr(4'd4, 8'h3A);
        rd(4'd4, v); chk("R11 jitter bits fixed", v, 8'h02);
        chk("R8 lctrl cleared link inactive", selfid_link_active, 0);
        chk("R9 pwr written", selfid_pwr_class, 2);
        bus_reset();
        rd(4'd4, v); chk("R8 node survives bus reset", v, 8'h02);
        wr(4'd4, 8'hC5);
        link_power_on = 1'b0; #0.5;
        chk("R8 link power off", selfid_link_active, 0);
        link_power_on = 1'b1; #0.5;
        chk("R8 link both on", selfid_link_active, 1);
        chk("R9 contender written", selfid_contender, 1);
        // R6: every gap value by write and by config packet
        for (int g = 0; g < 64; g++) begin
            wr(4'd1, g[7:0]);
            rd(4'd1, v); chk("R6 gap write", v, g);
            cfg_gap_valid = 1'b1; cfg_gap_value = 6'(63 - g);
            tick(); cfg_gap_valid = 1'b0;
            chk("R6 gap config", gap_count, 63 - g);
        end
        // R6: simultaneous write and config
        addr = 4'd1; wr_data = 8'h11; wr_en = 1'b1;
        cfg_gap_valid = 1'b1; cfg_gap_value = 6'h22;
        tick(); wr_en = 1'b0; cfg_gap_valid = 1'b0;
        chk("R6 write wins", gap_count, 8'h11);
        // R7: two-bus-reset rule
        wr(4'd1, 8'h05);
        bus_reset(); chk("R7 single reset keeps", gap_count, 5);
        bus_reset(); chk("R7 second reset max", gap_count, 63);
        wr(4'd1, 8'h07);
        bus_reset();
        cfg_gap_valid = 1'b1; cfg_gap_value = 6'h09; tick(); cfg_gap_valid = 1'b0;
        bus_reset(); chk("R7 update between keeps", gap_count, 9);
        bus_reset(); chk("R7 back to max", gap_count, 63);
        bus_reset(); chk("R7 stays max", gap_count, 63);
        // R5 / R4: bus reset request and holdoff
        link_busy = 1'b1;
        wr(4'd1, 8'hD2);
        chk("R5 request held while busy", bus_reset_req, 0);
        rd(4'd1, v); chk("R5 ibr readback", v, 8'hD2);
        link_busy = 1'b0; #0.5;
        chk("R5 request when idle", bus_reset_req, 1);
        chk("R4 holdoff out", root_holdoff, 1);
        bus_reset();
        chk("R5 request cleared", bus_reset_req, 0);
        rd(4'd1, v); chk("R4 holdoff kept, R5 ibr cleared", v, 8'h92);
        // R3: root
        root_won = 1'b1; tick(); root_won = 1'b0;
        rd(4'd0, v); chk("R3 root set", v[1], 1);
        root_won = 1'b1; bus_reset_evt = 1'b1; tick();
        root_won = 1'b0; bus_reset_evt = 1'b0;
        rd(4'd0, v); chk("R3 bus reset wins", v[1], 0);
        root_won = 1'b1; tick(); root_won = 1'b0;
        bus_reset();
        rd(4'd0, v); chk("R3 root cleared", v[1], 0);
        // R2: self-ID
        selfid_id = 6'h2A; selfid_done = 1'b1; tick(); selfid_done = 1'b0;
        chk("R2 valid", phy_id_valid, 1);
        chk("R2 status pulse", status_report, 1);
        rd(4'd0, v); chk("R2 id readback", v, (8'h2A << 2) | 1);
        tick();
        chk("R2 status single", status_report, 0);
        bus_reset();
        chk("R2 invalid after bus reset", phy_id_valid, 0);
        // R10: live cable power
        cable_pwr_ok = 1'b0;
        rd(4'd0, v); chk("R10 cable low", v[0], 0);
        cable_pwr_ok = 1'b1;
        rd(4'd0, v); chk("R10 cable high", v[0], 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule